// File: doc/BRIEF.md
# Memory power-down strobe generator

This block sits between a fast oscillator clock and external memories that have a separate power-down input. It divides the oscillator by a programmable even ratio to make the slower CPU phase clock. Once per phase-clock period it drives an active-low strobe that wakes the memory just before the phase clock rises and puts it back to sleep just after. The strobe opens two full oscillator cycles ahead of each phase-clock rising edge, which gives the memory its wake-up and address time. It closes half an oscillator cycle after that edge. Outside this 2.5-cycle window the memory stays in power-down.

When the phase-clock period is too short for the window to be useful, the strobe is simply held low. The same pin also serves as an ordinary port line. It stays in high impedance during and after reset, and it carries the strobe only once both the special-mode bit and the direction bit are set. A new divide ratio is taken up only at a phase-clock rising edge, so a window that has already started is never cut short.

Top module: `mem_pd_strobe`

## Requirements
- R1: With a divide code `s` on `divSel`, the phase clock has a period of N = 2*(s+1) oscillator cycles. It is high for the first N/2 cycles of each period and low for the last N/2, and each period starts with a rising edge.
- R2: When N > 6 and the pin is in strobe mode, `pinOut` is low for the whole of the last two oscillator cycles before each phase-clock rising edge.
- R3: When N > 6, `pinOut` stays low through the first half of the oscillator cycle that begins at the phase-clock rising edge. It is high in the second half of that cycle and in every other cycle of the period, so it is low for 2.5 cycles per period.
- R4: When N <= 6, `pinOut` is low on every half cycle while the pin is in strobe mode.
- R5: A change on `divSel` takes effect only at the next phase-clock rising edge. The period already running keeps its length.
- R6: `pinOe` is 0 while `rstN` is low and after reset until `cfgDir` is set. `pinOe` follows `cfgDir` one oscillator cycle later.
- R7: When `cfgDir`=1 and `cfgSpecial`=0, `pinOut` shows `portData` one cycle later. The strobe appears on `pinOut` only when `cfgSpecial`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; both edges are used |
| rstN | input | 1 | Asynchronous active-low reset |
| divSel | input | DIV_W | Divide code s; phase-clock period is 2*(s+1) cycles |
| cfgSpecial | input | 1 | 1 selects the strobe function for the pin |
| cfgDir | input | 1 | 1 makes the pin an output |
| portData | input | 1 | Plain port value used when the strobe function is off |
| phaseClk | output | 1 | Divided CPU phase clock |
| pinOut | output | 1 | Pad data: the active-low strobe or the port value |
| pinOe | output | 1 | Pad output enable; 0 means high impedance |

## Verification
The assertions check on every cycle that:
- a counter wrap is followed by a phase-clock rise;
- the divide code holds between wraps;
- the strobe is low at the end of the cycle before each rise;
- the strobe is high at the end of the first cycle of a slow period;
- the strobe is always low in fast periods;
- the output enable and the plain port path behave as specified.

The half-cycle placement of the window needs samples taken in both halves of every oscillator cycle, so only the bench can show it. The bench compares those samples with the window computed from the measured period. The same holds for exact period lengths across a sweep of all divide codes and across mid-period changes of the code.

// File: rtl/mps_pkg.sv
package mps_pkg;
  // Look-ahead strobes from the divider control to the pad datapath.
  // They describe the oscillator cycle that starts at the next rising edge.
  typedef struct packed {
    logic winNext;   // next cycle lies in the pre-edge wake-up window
    logic fastNext;  // next cycle belongs to a period too short for a window
  } mpsCtl_t;
endpackage

// File: rtl/mps_divider.sv
module mps_divider
  import mps_pkg::*;
#(
  parameter int DIV_W      = 3,
  parameter int WIN_CYC    = 2,
  parameter int FAST_MAX_N = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divSel,
  output mpsCtl_t          ctl,
  output logic             phaseClk,
  output logic             fastQ,
  output logic             wrap,
  output logic [DIV_W-1:0] nSelQ
);
  localparam int CNT_W = DIV_W + 1;
  localparam int NW    = DIV_W + 2;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cntNext;
  logic [DIV_W-1:0] selNext;
  logic [NW-1:0]    nCur;
  logic [NW-1:0]    nNext;
  logic [NW-1:0]    cntNextW;
  logic             phaseNext;

  function automatic logic [NW-1:0] periodOf(input logic [DIV_W-1:0] code);
    return {1'b0, code, 1'b0} + NW'(2);
  endfunction

  always_comb begin
    nCur      = periodOf(nSelQ);
    wrap      = ({1'b0, cnt} == (nCur - NW'(1)));
    selNext   = wrap ? divSel : nSelQ;
    nNext     = periodOf(selNext);
    cntNext   = wrap ? '0 : cnt + CNT_W'(1);
    cntNextW  = {1'b0, cntNext};
    phaseNext = cntNextW < (nNext >> 1);
    ctl.fastNext = nNext <= NW'(FAST_MAX_N);
    ctl.winNext  = cntNextW >= (nNext - NW'(WIN_CYC));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      nSelQ    <= '0;
      phaseClk <= 1'b0;
      fastQ    <= 1'b0;
    end else begin
      cnt      <= cntNext;
      nSelQ    <= selNext;
      phaseClk <= phaseNext;
      fastQ    <= ctl.fastNext;
    end
  end
endmodule

// File: rtl/mps_pad.sv
module mps_pad
  import mps_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  mpsCtl_t ctl,
  input  logic    cfgSpecial,
  input  logic    cfgDir,
  input  logic    portData,
  output logic    strobeN,
  output logic    pinOut,
  output logic    pinOe
);
  logic pdRise;  // rising-edge part: low through the pre-edge cycles
  logic pdFall;  // falling-edge copy: stretches the low by half a cycle
  logic specQ;
  logic dirQ;
  logic portQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pdRise <= 1'b1;
    else       pdRise <= !(ctl.fastNext || ctl.winNext);
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) pdFall <= 1'b1;
    else       pdFall <= pdRise;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      specQ <= 1'b0;
      dirQ  <= 1'b0;
      portQ <= 1'b0;
    end else begin
      specQ <= cfgSpecial;
      dirQ  <= cfgDir;
      portQ <= portData;
    end
  end

  always_comb begin
    strobeN = pdRise & pdFall;
    pinOut  = specQ ? strobeN : portQ;
    pinOe   = dirQ;
  end
endmodule

// File: rtl/mem_pd_strobe.sv
module mem_pd_strobe
  import mps_pkg::*;
#(
  parameter int DIV_W      = 3,
  parameter int WIN_CYC    = 2,
  parameter int FAST_MAX_N = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divSel,
  input  logic             cfgSpecial,
  input  logic             cfgDir,
  input  logic             portData,
  output logic             phaseClk,
  output logic             pinOut,
  output logic             pinOe
);
  mpsCtl_t          ctl;
  logic             fastQ;
  logic             wrap;
  logic [DIV_W-1:0] nSelQ;
  logic             strobeN;

  mps_divider #(
    .DIV_W(DIV_W), .WIN_CYC(WIN_CYC), .FAST_MAX_N(FAST_MAX_N)
  ) i_div (
    .clk(clk), .rstN(rstN), .divSel(divSel), .ctl(ctl),
    .phaseClk(phaseClk), .fastQ(fastQ), .wrap(wrap), .nSelQ(nSelQ)
  );

  mps_pad i_pad (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cfgSpecial(cfgSpecial),
    .cfgDir(cfgDir), .portData(portData), .strobeN(strobeN),
    .pinOut(pinOut), .pinOe(pinOe)
  );
endmodule

// File: rtl/mps_checker.sv
module mps_checker #(
  parameter int DIV_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgSpecial,
  input logic             cfgDir,
  input logic             portData,
  input logic             pinOut,
  input logic             pinOe,
  input logic             phaseClk,
  input logic             strobeN,
  input logic             fastQ,
  input logic             wrap,
  input logic [DIV_W-1:0] nSelQ
);
  // R1: a counter wrap starts a new phase-clock period
  a_r1_rise_after_wrap: assert property (@(posedge clk) disable iff (!rstN)
    wrap |=> $rose(phaseClk));

  // R2: the strobe is open at the end of the cycle before each rise
  a_r2_low_before_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(phaseClk) |-> !$past(strobeN));

  // R3: in a slow period the strobe has closed by the end of the first cycle
  a_r3_closed_after_half: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(phaseClk) && !fastQ) |-> strobeN);

  // R4: fast periods keep the strobe low
  a_r4_fast_low: assert property (@(posedge clk) disable iff (!rstN)
    fastQ |-> !strobeN);

  // R5: the divide code holds between wraps
  a_r5_sel_hold: assert property (@(posedge clk) disable iff (!rstN)
    !wrap |=> $stable(nSelQ));

  // R6: no drive without the direction bit
  a_r6_tristate: assert property (@(posedge clk) disable iff (!rstN)
    !cfgDir |=> !pinOe);

  // R6: high impedance while reset is held
  always @(negedge clk) begin
    if (!rstN) a_r6_reset_hiz: assert (!pinOe);
  end

  // R7: plain port path
  a_r7_port_path: assert property (@(posedge clk) disable iff (!rstN)
    (cfgDir && !cfgSpecial) |=> (pinOut == $past(portData)));
endmodule

bind mem_pd_strobe mps_checker #(.DIV_W(DIV_W)) i_chk (
  .clk(clk), .rstN(rstN), .cfgSpecial(cfgSpecial), .cfgDir(cfgDir),
  .portData(portData), .pinOut(pinOut), .pinOe(pinOe),
  .phaseClk(phaseClk), .strobeN(strobeN), .fastQ(fastQ),
  .wrap(wrap), .nSelQ(nSelQ)
);

// File: tb/test_mem_pd_strobe.sv
module test_mem_pd_strobe;
  localparam int DIV_W = 3;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [DIV_W-1:0] divSel = 3'd3;
  logic             cfgSpecial = 1'b0;
  logic             cfgDir = 1'b0;
  logic             portData = 1'b0;
  logic             phaseClk;
  logic             pinOut;
  logic             pinOe;

  int checks = 0;
  int errors = 0;
  int periods = 0;
  bit monOn = 1'b0;
  bit started = 1'b0;
  int idx = 0;
  int expN = 0;
  bit prevPhase = 1'b0;
  bit aArr[32];
  bit bArr[32];
  bit pArr[32];

  always #4 clk = ~clk;  // 125 MHz

  mem_pd_strobe #(.DIV_W(DIV_W)) i_mem_pd_strobe (
    .clk(clk), .rstN(rstN), .divSel(divSel), .cfgSpecial(cfgSpecial),
    .cfgDir(cfgDir), .portData(portData), .phaseClk(phaseClk),
    .pinOut(pinOut), .pinOe(pinOe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #6;
  endtask

  task automatic checkPeriod(input int len, input int n);
    periods++;
    chk(len == n, "R1 R5 period length", len, n);
    for (int p = 0; p < len && p < 32; p++) begin
      chk(pArr[p] == (p < n / 2), "R1 phase level", pArr[p], p < n / 2);
      if (n <= 6) begin
        chk(!aArr[p] && !bArr[p], "R4 fast always low", {aArr[p], bArr[p]}, 0);
      end else if (p >= n - 2) begin
        chk(!aArr[p] && !bArr[p], "R2 pre-edge window", {aArr[p], bArr[p]}, 0);
      end else if (p == 0) begin
        chk(!aArr[p] && bArr[p], "R3 half-cycle tail", {aArr[p], bArr[p]}, 1);
      end else begin
        chk(aArr[p] && bArr[p], "R3 powered down", {aArr[p], bArr[p]}, 3);
      end
    end
  endtask

  // Samples pinOut in each half of every oscillator cycle.
  always @(posedge clk) begin
    #2;
    if (!monOn) started = 1'b0;
    if (phaseClk && !prevPhase) begin
      if (monOn && started) checkPeriod(idx, expN);
      started = monOn;
      idx = 0;
      expN = 2 * (int'(divSel) + 1);
    end
    prevPhase = phaseClk;
    if (idx < 32) begin
      pArr[idx] = phaseClk;
      aArr[idx] = pinOut;
    end
    #4;
    if (idx < 32) bArr[idx] = pinOut;
    idx++;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    chk(pinOe == 1'b0, "R6 hiz in reset", pinOe, 0);
    rstN = 1'b1;
    step(3);
    chk(pinOe == 1'b0, "R6 hiz after reset", pinOe, 0);

    // Plain port mode
    cfgDir = 1'b1;
    for (int k = 0; k < 4; k++) begin
      portData = k[0];
      step(1);
      chk(pinOut == k[0], "R7 port data", pinOut, k[0]);
      chk(pinOe == 1'b1, "R6 drive on dir", pinOe, 1);
    end
    cfgDir = 1'b0;
    cfgSpecial = 1'b1;
    step(1);
    chk(pinOe == 1'b0, "R6 dir cleared", pinOe, 0);
    step(2);
    chk(pinOe == 1'b0, "R7 special without dir", pinOe, 0);

    // Strobe mode, sweep every divide code
    cfgDir = 1'b1;
    step(2);
    monOn = 1'b1;
    for (int s = 0; s < 8; s++) begin
      divSel = DIV_W'(s);
      step(70);
    end
    // Changes landing at arbitrary points of a period
    for (int k = 0; k < 24; k++) begin
      divSel = DIV_W'((k * 5 + 3) % 8);
      step((k * 7) % 13 + 1);
    end
    for (int s = 7; s >= 0; s--) begin
      divSel = DIV_W'(s);
      step(50);
    end
    monOn = 1'b0;
    step(2);
    chk(periods > 40, "R1 periods observed", periods, 41);

    // Back to port mode
    cfgSpecial = 1'b0;
    portData = 1'b1;
    step(1);
    chk(pinOut == 1'b1, "R7 port after strobe", pinOut, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule